// File: doc/BRIEF.md
# Expander Port Register Bank

This block is the pin-facing half of an eight-bit I/O expander. A host writes three control registers through a one-cycle strobe interface: drive levels, per-bit read inversion, and per-bit direction. The block decides which pins are driven and at what level. It also captures the synchronized pin levels into an input register when the host reads index 0.

Bit 0 is wired as an open-drain lane: it can sink current but never source it. The other seven lanes are push-pull. Direction bits reset to "input", so nothing is driven until the host clears them. The host reads any of the four register indices. The read data is valid in the cycle after the read strobe, and any other index reads as zero.

Top module: `gpx_port_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registers are set to their defaults: drive levels (index 1) 0x00, read inversion (index 2) 0xF0 and direction (index 3) 0xFF. All `pin_oe` bits are therefore 0.
- R2: A write strobe (`wr_en`=1) to index 1, 2 or 3 stores `wr_data` into that register at the clock edge.
- R3: A write strobe to index 0, or to any index from 4 to 7, changes no register and no pin output.
- R4: A read strobe to index 0 captures the pin levels through a two-flop synchronizer. A pin change must therefore be applied at least two cycles before the strobe cycle, and a change in the cycle just before is not yet seen. `rd_data` then returns each captured bit XORed with its inversion bit: 1 inverts, 0 passes.
- R5: The index 0 read reflects the pin levels whatever the direction bits are.
- R6: A read of index 1 returns the stored drive levels, not the pin levels.
- R7: A direction bit of 1 makes the lane an input: its `pin_oe` and `pin_out` are 0, whatever its drive-level bit holds.
- R8: On lanes 1 to 7, a direction bit of 0 sets `pin_oe` to 1 and `pin_out` to the drive-level bit.
- R9: On lane 0, `pin_out` is always 0. `pin_oe[0]` is 1 only when direction bit 0 is 0 and drive-level bit 0 is 0.
- R10: A read strobe to an index from 4 to 7 returns 0x00.
- R11: A write strobe in a cycle where `rst_n` is low is discarded, and the defaults of R1 remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| reg_idx | input | 3 | Register index for the strobe |
| wr_data | input | 8 | Data stored on a write strobe |
| rd_data | output | 8 | Data of the most recent read, valid in the cycle after the strobe |
| pin_in | input | 8 | Sensed pin levels, asynchronous |
| pin_out | output | 8 | Level to drive on each lane |
| pin_oe | output | 8 | Driver enable for each lane |

## Verification
A write is taken at the edge that ends its strobe cycle, so `pin_out` and `pin_oe` are checked in the low phase that follows that edge. Read data is due one cycle after the strobe. The driver tags each expected item with the cycle count at which it falls due, and the monitor compares it only in that cycle. A pin change is held for two cycles before the index 0 strobe when the new value is expected. A read issued in the very next cycle must still return the old level, which pins the synchronizer depth exactly.

// File: rtl/gpx_pkg.sv
`timescale 1ns/1ps
package gpx_pkg;
    localparam int unsigned PORT_W = 8;
    localparam int unsigned IDX_W  = 3;

    typedef logic [PORT_W-1:0] port_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam idx_t IDX_IN   = 3'd0;
    localparam idx_t IDX_OUT  = 3'd1;
    localparam idx_t IDX_POL  = 3'd2;
    localparam idx_t IDX_DIR  = 3'd3;
    localparam idx_t IDX_NONE = 3'd4;

    localparam port_t OUT_RST = 8'h00;
    localparam port_t POL_RST = 8'hF0;
    localparam port_t DIR_RST = 8'hFF;
    localparam port_t OD_MASK = 8'h01;

    typedef enum logic {LANE_PUSH_PULL, LANE_OPEN_DRAIN} lane_kind_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        idx_t  idx;
        port_t data;
    } host_req_t;

    typedef struct packed {
        port_t out_q;
        port_t pol_q;
        port_t dir_q;
        port_t in_q;
        idx_t  rd_sel;
    } bank_state_t;

    function automatic logic idx_writable(idx_t i);
        return (i == IDX_OUT) || (i == IDX_POL) || (i == IDX_DIR);
    endfunction

    function automatic port_t apply_polarity(port_t raw, port_t inv);
        return raw ^ inv;
    endfunction

    function automatic lane_kind_e lane_kind(port_t od_mask, int unsigned lane);
        return od_mask[lane] ? LANE_OPEN_DRAIN : LANE_PUSH_PULL;
    endfunction
endpackage

// File: rtl/gpx_sync.sv
`timescale 1ns/1ps
module gpx_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
`timescale 1ns/1ps
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter port_t OUT_DEF = OUT_RST,
    parameter port_t POL_DEF = POL_RST,
    parameter port_t DIR_DEF = DIR_RST
) (
    input  logic        clk,
    input  logic        rst_n,
    input  host_req_t   req,
    input  port_t       sync_pins,
    output bank_state_t st
);
    bank_state_t st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.out_q  <= OUT_DEF;
            st_q.pol_q  <= POL_DEF;
            st_q.dir_q  <= DIR_DEF;
            st_q.in_q   <= '0;
            st_q.rd_sel <= IDX_NONE;
        end else begin
            if (req.wr && idx_writable(req.idx)) begin
                case (req.idx)
                    IDX_OUT: st_q.out_q <= req.data;
                    IDX_POL: st_q.pol_q <= req.data;
                    default: st_q.dir_q <= req.data;
                endcase
            end
            if (req.rd) begin
                st_q.rd_sel <= req.idx;
                if (req.idx == IDX_IN) begin
                    st_q.in_q <= sync_pins;
                end
            end
        end
    end

    assign st = st_q;

    assert_defaults_held_R11: assert property (@(posedge clk)
        !rst_n |=> (st.out_q == OUT_DEF && st.pol_q == POL_DEF && st.dir_q == DIR_DEF))
        else $error("reset defaults lost");

    assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req.wr && req.idx == IDX_OUT) |=> st.out_q == $past(req.data))
        else $error("drive register not written");

    assert_bad_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req.wr && !idx_writable(req.idx)) |=>
            ($stable(st.out_q) && $stable(st.pol_q) && $stable(st.dir_q)))
        else $error("ignored write changed state");

    assert_input_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req.rd && req.idx == IDX_IN) |=> st.in_q == $past(sync_pins))
        else $error("input register not captured");
endmodule

// File: rtl/gpx_lane_drv.sv
`timescale 1ns/1ps
module gpx_lane_drv
    import gpx_pkg::*;
#(
    parameter port_t OD_PINS = OD_MASK
) (
    input  logic  clk,
    input  logic  rst_n,
    input  port_t out_q,
    input  port_t dir_q,
    output port_t pin_out,
    output port_t pin_oe
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_lane
        if (lane_kind(OD_PINS, i) == LANE_OPEN_DRAIN) begin : g_od
            assign pin_oe[i]  = !dir_q[i] && !out_q[i];
            assign pin_out[i] = 1'b0;

            assert_od_sink_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
                pin_oe[i] |-> (!pin_out[i] && !out_q[i] && !dir_q[i]))
                else $error("open-drain lane sourcing");
        end else begin : g_pp
            assign pin_oe[i]  = !dir_q[i];
            assign pin_out[i] = pin_oe[i] & out_q[i];

            assert_pp_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !dir_q[i] |-> (pin_oe[i] && pin_out[i] == out_q[i]))
                else $error("push-pull lane not driving");
        end

        assert_input_lane_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            dir_q[i] |-> (!pin_oe[i] && !pin_out[i]))
            else $error("input lane driven");
    end
endmodule

// File: rtl/gpx_rd_mux.sv
`timescale 1ns/1ps
module gpx_rd_mux
    import gpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  idx_t        rd_idx,
    input  bank_state_t st,
    output port_t       rd_data
);
    always_comb begin
        case (st.rd_sel)
            IDX_IN:  rd_data = apply_polarity(st.in_q, st.pol_q);
            IDX_OUT: rd_data = st.out_q;
            IDX_POL: rd_data = st.pol_q;
            IDX_DIR: rd_data = st.dir_q;
            default: rd_data = '0;
        endcase
    end

    assert_bad_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx > IDX_DIR) |=> rd_data == '0)
        else $error("out-of-range read not zero");

    assert_drive_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == IDX_OUT) |=> rd_data == st.out_q)
        else $error("drive register readback wrong");
endmodule

// File: rtl/gpx_port_bank.sv
`timescale 1ns/1ps
module gpx_port_bank
    import gpx_pkg::*;
#(
    parameter port_t       OUT_DEF     = OUT_RST,
    parameter port_t       POL_DEF     = POL_RST,
    parameter port_t       DIR_DEF     = DIR_RST,
    parameter port_t       OD_PINS     = OD_MASK,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    host_req_t   req;
    bank_state_t st;
    port_t       sync_pins;

    assign req = '{wr: wr_en, rd: rd_en, idx: reg_idx, data: wr_data};

    gpx_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_pins)
    );

    gpx_regfile #(.OUT_DEF(OUT_DEF), .POL_DEF(POL_DEF), .DIR_DEF(DIR_DEF)) u_regs (
        .clk(clk), .rst_n(rst_n), .req(req), .sync_pins(sync_pins), .st(st)
    );

    gpx_lane_drv #(.OD_PINS(OD_PINS)) u_lanes (
        .clk(clk), .rst_n(rst_n), .out_q(st.out_q), .dir_q(st.dir_q),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    gpx_rd_mux u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(reg_idx),
        .st(st), .rd_data(rd_data)
    );

    assert_reset_no_drive_R1: assert property (@(posedge clk)
        !rst_n |=> pin_oe == '0)
        else $error("pins driven after reset");
endmodule

// File: tb/gpx_port_bank_tb.sv
`timescale 1ns/1ps
module gpx_port_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] reg_idx = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] rd_data, pin_out, pin_oe;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int         kind;
        int         due;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpx_port_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic push(int kind, int due, logic [7:0] exp, string tag);
        item_t it;
        it.kind = kind; it.due = due; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(logic [2:0] idx, logic [7:0] d);
        wr_en = 1'b1; reg_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] idx, logic [7:0] exp, string tag);
        rd_en = 1'b1; reg_idx = idx;
        push(0, cyc + 1, exp, tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_pins(logic [7:0] exp_oe, logic [7:0] exp_out, string tag);
        push(1, cyc, exp_oe, tag);
        push(2, cyc, exp_out, tag);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each expected item in the cycle it falls due
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = (it.kind == 0) ? rd_data : (it.kind == 1) ? pin_oe : pin_out;
                n_checks++;
                if (it.due != cyc || act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s: actual %02h expected %02h",
                             it.tag, (it.kind == 0) ? "rd_data" : (it.kind == 1) ? "pin_oe" : "pin_out",
                             act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk_pins(8'h00, 8'h00, "R1 reset pins");
        rd(3'd1, 8'h00, "R1 drive default");
        rd(3'd2, 8'hF0, "R1 inversion default");
        rd(3'd3, 8'hFF, "R1 direction default");
        // R4 inversion with default mask, R5 all inputs
        pin_in = 8'hA5;
        idle(2);
        rd(3'd0, 8'h55, "R4 default inversion");
        // R2 write inversion, R4 pass-through
        wr(3'd2, 8'h00);
        rd(3'd0, 8'hA5, "R4 no inversion");
        // R7 drive bits ignored while inputs, R6 readback
        wr(3'd1, 8'h5A);
        chk_pins(8'h00, 8'h00, "R7 inputs not driven");
        rd(3'd1, 8'h5A, "R6 drive readback");
        // R8 R9 all outputs, lane0 low -> sinks
        wr(3'd3, 8'h00);
        chk_pins(8'hFF, 8'h5A, "R8 R9 all outputs");
        wr(3'd1, 8'h5B);
        chk_pins(8'hFE, 8'h5A, "R9 lane0 released when high");
        // R5 input read follows pins on output lanes, R6 not pins
        pin_in = 8'h3C;
        idle(2);
        rd(3'd0, 8'h3C, "R5 input read with outputs");
        rd(3'd1, 8'h5B, "R6 drive not pin level");
        // R7 R8 mixed direction
        wr(3'd3, 8'h0F);
        chk_pins(8'hF0, 8'h50, "R7 R8 mixed direction");
        // R3 ignored writes
        wr(3'd0, 8'h77);
        wr(3'd5, 8'h00);
        wr(3'd7, 8'hAA);
        chk_pins(8'hF0, 8'h50, "R3 pins after ignored writes");
        rd(3'd1, 8'h5B, "R3 drive unchanged");
        rd(3'd2, 8'h00, "R3 inversion unchanged");
        rd(3'd3, 8'h0F, "R3 direction unchanged");
        rd(3'd0, 8'h3C, "R3 input unchanged");
        // R10 out-of-range reads
        rd(3'd4, 8'h00, "R10 index 4");
        rd(3'd3, 8'h0F, "R10 setup");
        rd(3'd7, 8'h00, "R10 index 7");
        // R4 synchronizer depth boundary
        pin_in = 8'hC3;
        rd(3'd0, 8'h3C, "R4 change too recent");
        idle(1);
        rd(3'd0, 8'hC3, "R4 change after two cycles");
        wr(3'd2, 8'h0F);
        rd(3'd0, 8'hCC, "R4 mixed inversion");
        // R11 reset mid-run discards writes
        rst_n = 1'b0;
        wr(3'd3, 8'h00);
        idle(1);
        chk_pins(8'h00, 8'h00, "R11 pins in reset");
        rst_n = 1'b1;
        rd(3'd3, 8'hFF, "R11 direction after reset");
        rd(3'd1, 8'h00, "R11 drive after reset");
        rd(3'd2, 8'hF0, "R11 inversion after reset");
        idle(2);
        rd(3'd0, 8'h33, "R1 R4 input after reset");
        idle(3);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule